// File: doc/BRIEF.md
# Level-Checked Byte FIFO

A single-clock FIFO that holds 256 bytes and queues entries of a selectable width (8, 16 or 32 bits) on the transmit or receive side of a serial controller. Data enters and leaves on valid/ready streams. A plain reset pin empties the queue. A plain start pin opens both streams; while it is low the queue holds its contents and moves nothing. A status word reports the fill level in entries together with full and empty flags. Three 6-bit check levels and an 8-bit threshold are compared with the fill level and drive level-sensitive watermark flags for an interrupt block.

Back-pressure rules: `in_ready` is high exactly when the queue is started and has room for one more entry of the current width. An entry is taken on a cycle with `in_valid` and `in_ready` both high. `out_valid` is high exactly when the queue is started and holds at least one entry, and `out_data` is then the oldest entry. An entry is removed on a cycle with `out_valid` and `out_ready` both high. A push and a pop may complete in the same cycle. The entry width may only be changed while the queue is empty.

Top module: `lcf_fifo`

## Requirements
- R1: `width_sel` sets the entry width: 0 is 8-bit, 1 is 16-bit, and 2 or 3 is 32-bit. Capacity is 256, 128 or 64 entries. Only the low bytes of the selected width are stored, and `out_data` is zero above the selected width.
- R2: Entries leave in the order they were accepted, with their stored bits unchanged.
- R3: `status[7:0]` is the number of stored entries modulo 256, `status[8]` is full and `status[9]` is empty. All three change in the cycle after the push or pop that alters them.
- R4: `in_ready` equals start AND not full. When the queue is started and full, `in_valid` stores nothing, and `overflow` is high for exactly the next cycle.
- R5: `out_valid` equals start AND not empty. When the queue is started and empty, `out_ready` removes nothing, and `underflow` is high for exactly the next cycle.
- R6: While `op_start` is low, `in_ready` and `out_valid` are low, the contents and the level are kept, and no overflow or underflow is reported.
- R7: `op_reset` empties the queue in the next cycle. It overrides a push or pop in the same cycle, and that cycle reports no overflow or underflow.
- R8: `lvl_low` is high when entries <= `chk_low`, `lvl_mid` is high when entries >= `chk_mid`, and `lvl_high` is high when entries >= `chk_high`. Entries are counted in units of the current width.
- R9: `thr_reached` is high while entries >= `thresh`.
- R10: A push and a pop that complete in the same cycle leave the level unchanged and keep the order.
- R11: After `rst_n` is released the queue is empty: `status` = 10'h200, `overflow` and `underflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| width_sel | input | 2 | Entry width select |
| op_reset | input | 1 | Empty the queue |
| op_start | input | 1 | Enable data flow |
| chk_low | input | 6 | Low check level |
| chk_mid | input | 6 | Middle check level |
| chk_high | input | 6 | High check level |
| thresh | input | 8 | Threshold level |
| in_valid | input | 1 | Write stream valid |
| in_ready | output | 1 | Write stream ready |
| in_data | input | 32 | Write data |
| out_valid | output | 1 | Read stream valid |
| out_ready | input | 1 | Read stream ready |
| out_data | output | 32 | Oldest entry |
| status | output | 10 | {empty, full, level[7:0]} |
| overflow | output | 1 | Push attempt while full, one cycle |
| underflow | output | 1 | Pop attempt while empty, one cycle |
| lvl_low | output | 1 | Level at or below low check |
| lvl_mid | output | 1 | Level at or above middle check |
| lvl_high | output | 1 | Level at or above high check |
| thr_reached | output | 1 | Level at or above threshold |

## Verification
Two pairs of events can fall in the same cycle. In the first, a push and a pop complete together. In the second, an `op_reset` meets a push, a pop, or an attempt on a full or empty queue. Phases with both streams held active provoke the first pair, and phases that fire reset randomly on top of random traffic provoke the second. A queue-based model judges every cycle: concurrent handshakes must leave the level unchanged and keep the order, and a reset must win over all traffic, with no overflow or underflow reported for that cycle.

// File: rtl/lcf_pkg.sv
package lcf_pkg;
  typedef enum logic [1:0] {EW_8 = 2'd0, EW_16 = 2'd1, EW_32 = 2'd2, EW_32B = 2'd3} ew_e;

  // log2 of the entry size in bytes
  function automatic logic [1:0] lane_shift(input logic [1:0] sel);
    case (ew_e'(sel))
      EW_8:    return 2'd0;
      EW_16:   return 2'd1;
      default: return 2'd2;
    endcase
  endfunction
endpackage

// File: rtl/lcf_level.sv
module lcf_level #(
  parameter int CNT_W = 9,
  parameter int CHK_W = 6,
  parameter int THR_W = 8
) (
  input  logic [CNT_W-1:0] cnt_bytes,
  input  logic [1:0]       shift,
  input  logic [CHK_W-1:0] chk_low,
  input  logic [CHK_W-1:0] chk_mid,
  input  logic [CHK_W-1:0] chk_high,
  input  logic [THR_W-1:0] thr,
  output logic [CNT_W-1:0] entries,
  output logic             below_low,
  output logic             above_mid,
  output logic             above_high,
  output logic             thr_hit
);
  always_comb begin
    entries    = cnt_bytes >> shift;
    below_low  = entries <= CNT_W'(chk_low);
    above_mid  = entries >= CNT_W'(chk_mid);
    above_high = entries >= CNT_W'(chk_high);
    thr_hit    = entries >= CNT_W'(thr);
  end
endmodule

// File: rtl/lcf_store.sv
module lcf_store #(
  parameter int DEPTH_BYTES = 256,
  parameter int LANES       = 4,
  localparam int PTR_W      = $clog2(DEPTH_BYTES),
  localparam int NB_W       = $clog2(LANES) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [NB_W-1:0]    nbytes,
  input  logic [8*LANES-1:0] wr_data,
  output logic [8*LANES-1:0] rd_data
);
  logic [7:0]       mem [DEPTH_BYTES];
  logic [PTR_W-1:0] wp, rp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
    end else if (clr) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (wr_en) wp <= wp + PTR_W'(nbytes);
      if (rd_en) rp <= rp + PTR_W'(nbytes);
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (wr_en && (NB_W'(k) < nbytes)) mem[wp + PTR_W'(k)] <= wr_data[8*k +: 8];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_data[8*g +: 8] = (NB_W'(g) < nbytes) ? mem[rp + PTR_W'(g)] : 8'h00;
  end
endmodule

// File: rtl/lcf_fifo.sv
module lcf_fifo #(
  parameter int DEPTH_BYTES = 256,
  parameter int DATA_W      = 32,
  parameter int CHK_W       = 6,
  parameter int THR_W       = 8,
  localparam int LANES      = DATA_W / 8,
  localparam int CNT_W      = $clog2(DEPTH_BYTES) + 1,
  localparam int NB_W       = $clog2(LANES) + 1,
  localparam int ST_W       = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        width_sel,
  input  logic              op_reset,
  input  logic              op_start,
  input  logic [CHK_W-1:0]  chk_low,
  input  logic [CHK_W-1:0]  chk_mid,
  input  logic [CHK_W-1:0]  chk_high,
  input  logic [THR_W-1:0]  thresh,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic [ST_W-1:0]   status,
  output logic              overflow,
  output logic              underflow,
  output logic              lvl_low,
  output logic              lvl_mid,
  output logic              lvl_high,
  output logic              thr_reached
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH_BYTES);

  logic [1:0]       shift;
  logic [NB_W-1:0]  nbytes;
  logic [CNT_W-1:0] cnt_q, cnt_d, nb_c, room, entries;
  logic             full, empty, push, pop;

  always_comb begin
    shift     = lcf_pkg::lane_shift(width_sel);
    nbytes    = NB_W'(1) << shift;
    nb_c      = CNT_W'(nbytes);
    room      = DEPTH_C - cnt_q;
    full      = room < nb_c;
    empty     = cnt_q == '0;
    in_ready  = op_start & ~full;
    out_valid = op_start & ~empty;
    push      = in_valid & in_ready & ~op_reset;
    pop       = out_valid & out_ready & ~op_reset;
    cnt_d     = cnt_q;
    if (op_reset) begin
      cnt_d = '0;
    end else begin
      if (push) cnt_d = cnt_d + nb_c;
      if (pop)  cnt_d = cnt_d - nb_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      overflow  <= ~op_reset & op_start & in_valid & full;
      underflow <= ~op_reset & op_start & out_ready & empty;
    end
  end

  lcf_store #(.DEPTH_BYTES(DEPTH_BYTES), .LANES(LANES)) i_store (
    .clk(clk), .rst_n(rst_n), .clr(op_reset), .wr_en(push), .rd_en(pop),
    .nbytes(nbytes), .wr_data(in_data), .rd_data(out_data)
  );

  lcf_level #(.CNT_W(CNT_W), .CHK_W(CHK_W), .THR_W(THR_W)) i_level (
    .cnt_bytes(cnt_q), .shift(shift), .chk_low(chk_low), .chk_mid(chk_mid),
    .chk_high(chk_high), .thr(thresh), .entries(entries), .below_low(lvl_low),
    .above_mid(lvl_mid), .above_high(lvl_high), .thr_hit(thr_reached)
  );

  assign status = {empty, full, entries[CNT_W-2:0]};
endmodule

// File: rtl/lcf_checker.sv
module lcf_checker #(
  parameter int ST_W = 10
) (
  input logic            clk,
  input logic            rst_n,
  input logic [1:0]      width_sel,
  input logic            op_reset,
  input logic            op_start,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic            overflow,
  input logic            underflow,
  input logic [ST_W-1:0] status
);
  localparam int FULL_B  = ST_W - 2;
  localparam int EMPTY_B = ST_W - 1;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    status[FULL_B] |-> !in_ready); // R4
  AST_EMPTY_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    status[EMPTY_B] |-> !out_valid); // R5
  AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !op_start |-> (!in_ready && !out_valid)); // R6
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_start && !op_reset) |=> ($stable(status) || !$stable(width_sel))); // R6
  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    op_reset |=> (status[EMPTY_B] && status[FULL_B-1:0] == '0 && !overflow && !underflow)); // R7
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(op_start && in_valid && status[FULL_B] && !op_reset)); // R4
  AST_UNF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> $past(op_start && out_ready && status[EMPTY_B] && !op_reset)); // R5
  AST_PAIR_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && out_valid && out_ready && !op_reset)
      |=> ($stable(status) || !$stable(width_sel))); // R10
endmodule

bind lcf_fifo lcf_checker #(.ST_W(ST_W)) i_lcf_checker (
  .clk(clk), .rst_n(rst_n), .width_sel(width_sel), .op_reset(op_reset),
  .op_start(op_start), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .overflow(overflow),
  .underflow(underflow), .status(status)
);

// File: tb/test_lcf_fifo.sv
module test_lcf_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  width_sel = 2'd0;
  logic        op_reset = 1'b0, op_start = 1'b0;
  logic [5:0]  chk_low = '0, chk_mid = '0, chk_high = '0;
  logic [7:0]  thresh = '0;
  logic        in_valid = 1'b0, out_ready = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready, out_valid, overflow, underflow;
  logic        lvl_low, lvl_mid, lvl_high, thr_reached;
  logic [31:0] out_data;
  logic [9:0]  status;

  int n_chk = 0, n_fail = 0;
  int q[$];
  bit ovf_e = 0, unf_e = 0;
  string ptag = "R11";

  always #4 clk = ~clk;

  lcf_fifo i_lcf_fifo (
    .clk(clk), .rst_n(rst_n), .width_sel(width_sel), .op_reset(op_reset),
    .op_start(op_start), .chk_low(chk_low), .chk_mid(chk_mid), .chk_high(chk_high),
    .thresh(thresh), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .status(status), .overflow(overflow), .underflow(underflow),
    .lvl_low(lvl_low), .lvl_mid(lvl_mid), .lvl_high(lvl_high),
    .thr_reached(thr_reached)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s [%s] actual=%h expected=%h at %0t", tag, ptag, act, exp, $time);
    end
  endtask

  // compare all outputs against the model, then advance the model by one edge
  task automatic step_model();
    int nb, cap, ents;
    bit full, empty, exp_ir, exp_ov;
    logic [31:0] mask;
    nb   = (width_sel == 2'd0) ? 1 : (width_sel == 2'd1) ? 2 : 4;
    cap  = 256 / nb;
    mask = (nb == 1) ? 32'hFF : (nb == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
    ents = q.size();
    full = (ents == cap);
    empty = (ents == 0);
    exp_ir = op_start && !full;
    exp_ov = op_start && !empty;
    chk("R4 in_ready", 32'(in_ready), 32'(exp_ir));
    chk("R5 out_valid", 32'(out_valid), 32'(exp_ov));
    if (exp_ov) chk("R2 R1 out_data", out_data, q[0]);
    chk("R3 status", 32'(status), 32'((empty ? 512 : 0) | (full ? 256 : 0) | (ents & 255)));
    chk("R8 lvl_low", 32'(lvl_low), 32'(ents <= int'(chk_low)));
    chk("R8 lvl_mid", 32'(lvl_mid), 32'(ents >= int'(chk_mid)));
    chk("R8 lvl_high", 32'(lvl_high), 32'(ents >= int'(chk_high)));
    chk("R9 thr_reached", 32'(thr_reached), 32'(ents >= int'(thresh)));
    chk("R4 overflow", 32'(overflow), 32'(ovf_e));
    chk("R5 underflow", 32'(underflow), 32'(unf_e));
    if (op_reset) begin
      q.delete();
      ovf_e = 0;
      unf_e = 0;
    end else begin
      ovf_e = op_start && in_valid && full;
      unf_e = op_start && out_ready && empty;
      if (exp_ov && out_ready) void'(q.pop_front());
      if (exp_ir && in_valid) q.push_back(in_data & mask);
    end
  endtask

  task automatic run(input string tag, input int n, input int p_in, input int p_out,
                     input bit start, input int p_rst);
    ptag = tag;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      op_start  = start;
      in_valid  = ($urandom_range(99) < p_in);
      out_ready = ($urandom_range(99) < p_out);
      in_data   = $urandom;
      op_reset  = ($urandom_range(99) < p_rst);
      #1;
      step_model();
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R11: reset state
    chk("R11 status after reset", 32'(status), 32'h200);
    chk("R11 overflow after reset", 32'(overflow), 32'h0);
    chk("R11 underflow after reset", 32'(underflow), 32'h0);
    for (int w = 0; w < 4; w++) begin
      @(negedge clk);
      width_sel = 2'(w);
      chk_low   = 6'($urandom_range(63));
      chk_mid   = 6'($urandom_range(63));
      chk_high  = 6'($urandom_range(63));
      thresh    = 8'($urandom_range(255));
      run("R7 clear", 2, 0, 0, 1'b0, 100);
      run("R1 fill", 320, 90, 10, 1'b1, 0);
      run("R6 stopped", 40, 60, 60, 1'b0, 0);
      run("R10 concurrent", 60, 100, 100, 1'b1, 0);
      run("R1 drain", 320, 10, 90, 1'b1, 0);
      run("R10 mixed", 200, 60, 50, 1'b1, 0);
      run("R7 reset collision", 150, 70, 40, 1'b1, 8);
      run("R7 clear", 1, 0, 0, 1'b0, 100);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule